// File: doc/BRIEF.md
# Serial-Bus PHY Control and Status Register Bank

This block holds the register file that a link-layer controller reads and writes to configure a two-port serial-bus physical layer and to learn about its events. Some fields report fixed capabilities: the port count, the speed the node supports, its worst-case repeat delay and its jitter. Others are control bits. The link-active, contender and power-class values feed the self-ID packet builder. A watchdog enable gates interrupts. A short-reset request asks the arbitration logic for a short bus reset. The contender bit, the power class and the reported speed take their values from strap inputs at reset.

Four event flags latch conditions until software writes a one to clear them: loop detected, power lost (a falling edge on the synchronized cable-power input), timeout and port resume. The link-on interrupt is a level. It stays high while the loop, power-fail or timeout flag is set, unless both the low-power-status input and the watchdog bit are low. A requested short reset clears itself when the bus reset begins. A counter then holds a drive output high for a fixed time derived from the clock frequency.

Top module: `phy_csr_bank`

## Requirements
- R1: Address 0 reads 0x20: the port count 2 in bits [7:4] and the delay code 0 in bits [3:0]. Writes to address 0 leave it unchanged.
- R2: Address 1 reads the speed code in bits [7:5], the jitter code 010 in bits [4:2], link-active in bit [1] and contender in bit [0]. The speed code is 010 when `strap_speed` is 1 and 001 when it is 0. Link-active resets to 1 and contender resets to `strap_contender`. A write updates only bits [1:0].
- R3: `sid_link` equals link-active AND `lps`. `sid_contender` equals the contender bit. `sid_pwr` equals the power class.
- R4: Address 2 bits [7:5] hold the power class, which resets to `strap_pwr` and is writable. Bit [4] holds the watchdog enable, which resets to 0.
- R5: Address 2 bit [2] is the loop flag. It is set by `loop_det` and cleared by writing 1. Writing 0 has no effect. A set in the same cycle as a clear wins.
- R6: Address 2 bit [1] is the power-fail flag. It resets to 1 and is cleared by writing 1. It becomes visible on the third rising edge after `cps` falls: two synchronizer stages, then an edge compare.
- R7: Address 2 bit [3] is the short-reset request. Writing 1 sets it, writing 0 has no effect, and `short_reset_req` mirrors it. It clears on the edge where `bus_reset_start` is seen while it is set.
- R8: On that edge `short_reset_drive` goes high for ceil(CLK_MHZ*SHORT_RESET_NS/1000) cycles, which is 65 at 50 MHz and 1300 ns. `bus_reset_start` without a pending request does not drive it.
- R9: Address 3 bit [1] is the timeout flag. It is set by `timeout_evt` and cleared by writing 1.
- R10: Address 3 bit [0] is the port-event flag. It is set when the watchdog is 1, `strap_susres` is 1 and any `port_resume` bit is 1. It is cleared by writing 1.
- R11: `link_on_irq` = (`lps` OR watchdog) AND (loop OR power-fail OR timeout).
- R12: A cycle with `reg_rd` high loads `reg_rdata` with the addressed register on that edge. Otherwise `reg_rdata` holds its value, and it resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| strap_speed | input | 1 | Speed strap: 1 selects the higher speed code |
| strap_contender | input | 1 | Reset value of the contender bit |
| strap_pwr | input | 3 | Reset value of the power class |
| strap_susres | input | 1 | Suspend/resume support strap |
| lps | input | 1 | Link power status |
| cps | input | 1 | Cable power status (asynchronous) |
| loop_det | input | 1 | Loop-detected event pulse |
| timeout_evt | input | 1 | Timeout event pulse |
| port_resume | input | NUM_PORTS | Per-port resume event |
| bus_reset_start | input | 1 | Bus reset is beginning |
| sid_link | output | 1 | Self-ID link-active bit |
| sid_contender | output | 1 | Self-ID contender bit |
| sid_pwr | output | 3 | Self-ID power class |
| short_reset_req | output | 1 | Short arbitrated reset requested |
| short_reset_drive | output | 1 | Short reset signalling in progress |
| link_on_irq | output | 1 | Level link-on interrupt |

## Verification
The bench builds the block with its defaults: CLK_MHZ of 50, SHORT_RESET_NS of 1300 and NUM_PORTS of 2. At those values the short-reset pulse is 65 cycles long, short enough to count edge by edge against the reference model and to confirm its exact length. Two ports are enough to show that a resume on either one sets the port-event flag. Two resets with opposite strap settings cover both speed codes, both contender values and the suspend/resume gate.

// File: rtl/phy_csr_pkg.sv
// Shared constants for the PHY control/status register bank.
// Assumes an 8-bit data path and four registers selected by a 2-bit address.
package phy_csr_pkg;
    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    typedef enum logic [REG_AW-1:0] {
        ADDR_CAPS = 2'd0,
        ADDR_LINK = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_EVT  = 2'd3
    } csr_addr_e;

    localparam logic [3:0] DELAY_CODE  = 4'b0000;
    localparam logic [2:0] JITTER_CODE = 3'b010;
    localparam logic [2:0] SPEED_LOW   = 3'b001;
    localparam logic [2:0] SPEED_HIGH  = 3'b010;

    // Event flag indices
    localparam int FLG_PORT   = 0;
    localparam int FLG_PWR    = 1;
    localparam int FLG_LOOP   = 2;
    localparam int FLG_TMO    = 3;
    localparam int NUM_FLAGS  = 4;
endpackage

// File: rtl/csr_edge_sync.sv
// Synchronizes an asynchronous level through STAGES flops and reports a
// one-cycle falling-edge pulse by comparing the last stage with a delayed copy.
// Assumes the input is quasi-static relative to the clock; flops reset to 0,
// so a level that is low at reset produces no edge.
module csr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the input through the synchronizer and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/csr_event_flag.sv
// Sticky event flag with write-one-to-clear; a set in the same cycle as a
// clear wins so that no event is lost. Reset value is a parameter.
module csr_event_flag #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Latch events; clear only when no new event arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= RESET_VAL;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end
endmodule

// File: rtl/csr_short_reset.sv
// Holds the short-reset request bit and times the short reset signalling.
// The request self-clears when the bus reset begins while it is pending, and
// a down-counter then keeps drive_o high for CYCLES clocks.
module csr_short_reset #(
    parameter int CYCLES = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_set_i,
    input  logic bus_reset_start_i,
    output logic req_o,
    output logic drive_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    // Request bit plus duration counter; the start of the reset beats a new write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o <= 1'b0;
            cnt_q <= '0;
        end else if (bus_reset_start_i && req_o) begin
            req_o <= 1'b0;
            cnt_q <= LOAD;
        end else begin
            if (req_set_i)     req_o <= 1'b1;
            if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        end
    end

    assign drive_o = (cnt_q != '0);
endmodule

// File: rtl/phy_csr_bank.sv
// Control and status register bank of a two-port serial-bus PHY.
// Holds capability fields, strap-loaded control bits, four sticky event
// flags, the short-reset request and the link-on interrupt level.
// Assumes one register access per cycle and straps stable while rst_n is low.
module phy_csr_bank
    import phy_csr_pkg::*;
#(
    parameter int CLK_MHZ        = 50,
    parameter int SHORT_RESET_NS = 1300,
    parameter int NUM_PORTS      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [REG_DW-1:0]    reg_wdata,
    input  logic                 reg_rd,
    output logic [REG_DW-1:0]    reg_rdata,
    input  logic                 strap_speed,
    input  logic                 strap_contender,
    input  logic [2:0]           strap_pwr,
    input  logic                 strap_susres,
    input  logic                 lps,
    input  logic                 cps,
    input  logic                 loop_det,
    input  logic                 timeout_evt,
    input  logic [NUM_PORTS-1:0] port_resume,
    input  logic                 bus_reset_start,
    output logic                 sid_link,
    output logic                 sid_contender,
    output logic [2:0]           sid_pwr,
    output logic                 short_reset_req,
    output logic                 short_reset_drive,
    output logic                 link_on_irq
);
    localparam int SHORT_CYCLES = (CLK_MHZ * SHORT_RESET_NS + 999) / 1000;
    localparam logic [NUM_FLAGS-1:0] FLAG_RST = NUM_FLAGS'(1) << FLG_PWR;

    logic       link_active_q;
    logic       contender_q;
    logic [2:0] pwr_class_q;
    logic       watchdog_q;
    logic       wr_link, wr_ctrl, wr_evt;
    logic       cps_fall;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
    logic [REG_DW-1:0]    rd_word;

    // Decode write strobes per register.
    always_comb begin
        wr_link = reg_wr && (reg_addr == ADDR_LINK);
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
        wr_evt  = reg_wr && (reg_addr == ADDR_EVT);
    end

    // Read/write control bits; reset values come from the straps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_active_q <= 1'b1;
            contender_q   <= strap_contender;
            pwr_class_q   <= strap_pwr;
            watchdog_q    <= 1'b0;
        end else begin
            if (wr_link) begin
                link_active_q <= reg_wdata[1];
                contender_q   <= reg_wdata[0];
            end
            if (wr_ctrl) begin
                pwr_class_q <= reg_wdata[7:5];
                watchdog_q  <= reg_wdata[4];
            end
        end
    end

    csr_edge_sync #(.STAGES(2)) u_cps_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cps),
        .fall_o  (cps_fall)
    );

    // Event sources and write-one-to-clear strobes per flag.
    always_comb begin
        flag_set[FLG_PORT] = watchdog_q && strap_susres && (|port_resume);
        flag_set[FLG_PWR]  = cps_fall;
        flag_set[FLG_LOOP] = loop_det;
        flag_set[FLG_TMO]  = timeout_evt;
        flag_clr[FLG_PORT] = wr_evt  && reg_wdata[0];
        flag_clr[FLG_PWR]  = wr_ctrl && reg_wdata[1];
        flag_clr[FLG_LOOP] = wr_ctrl && reg_wdata[2];
        flag_clr[FLG_TMO]  = wr_evt  && reg_wdata[1];
    end

    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        csr_event_flag #(.RESET_VAL(FLAG_RST[gi])) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[gi]),
            .clr_i  (flag_clr[gi]),
            .flag_o (flag_q[gi])
        );
    end

    csr_short_reset #(.CYCLES(SHORT_CYCLES)) u_short_rst (
        .clk               (clk),
        .rst_n             (rst_n),
        .req_set_i         (wr_ctrl && reg_wdata[3]),
        .bus_reset_start_i (bus_reset_start),
        .req_o             (short_reset_req),
        .drive_o           (short_reset_drive)
    );

    // Assemble the addressed register for a read.
    always_comb begin
        unique case (reg_addr)
            ADDR_CAPS: rd_word = {4'(NUM_PORTS), DELAY_CODE};
            ADDR_LINK: rd_word = {(strap_speed ? SPEED_HIGH : SPEED_LOW),
                                  JITTER_CODE, link_active_q, contender_q};
            ADDR_CTRL: rd_word = {pwr_class_q, watchdog_q, short_reset_req,
                                  flag_q[FLG_LOOP], flag_q[FLG_PWR], 1'b0};
            ADDR_EVT:  rd_word = {6'b0, flag_q[FLG_TMO], flag_q[FLG_PORT]};
            default:   rd_word = '0;
        endcase
    end

    // Register read data on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
    end

    // Self-ID exports and the gated interrupt level.
    always_comb begin
        sid_link      = link_active_q & lps;
        sid_contender = contender_q;
        sid_pwr       = pwr_class_q;
        link_on_irq   = (lps | watchdog_q) &
                        (flag_q[FLG_LOOP] | flag_q[FLG_PWR] | flag_q[FLG_TMO]);
    end
endmodule

// File: rtl/phy_csr_bank_chk.sv
// Property checker for phy_csr_bank, attached through bind below.
module phy_csr_bank_chk (
    input logic clk,
    input logic rst_n,
    input logic lps,
    input logic loop_det,
    input logic bus_reset_start,
    input logic watchdog_q,
    input logic cps_fall,
    input logic loop_flag,
    input logic pf_flag,
    input logic short_reset_req,
    input logic short_reset_drive,
    input logic sid_link,
    input logic link_on_irq
);
    // R3
    sid_link_lps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sid_link |-> lps);

    // R5
    loop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_det |=> loop_flag);

    // R6
    pwr_fail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cps_fall |=> pf_flag);

    // R7
    req_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_start && short_reset_req) |=> !short_reset_req);

    // R8
    drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_start && short_reset_req) |=> short_reset_drive);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_on_irq |-> (lps || watchdog_q));
endmodule

bind phy_csr_bank phy_csr_bank_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .lps               (lps),
    .loop_det          (loop_det),
    .bus_reset_start   (bus_reset_start),
    .watchdog_q        (watchdog_q),
    .cps_fall          (cps_fall),
    .loop_flag         (flag_q[2]),
    .pf_flag           (flag_q[1]),
    .short_reset_req   (short_reset_req),
    .short_reset_drive (short_reset_drive),
    .sid_link          (sid_link),
    .link_on_irq       (link_on_irq)
);

// File: tb/phy_csr_bank_tb_top.sv
module phy_csr_bank_tb_top;
    localparam int SHORT_EXP = 65;   // 1300 ns / 20 ns

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       strap_speed = 1'b1, strap_contender = 1'b1, strap_susres = 1'b1;
    logic [2:0] strap_pwr = 3'b101;
    logic       lps = 1'b1, cps = 1'b1, loop_det = 1'b0, timeout_evt = 1'b0;
    logic [1:0] port_resume = '0;
    logic       bus_reset_start = 1'b0;
    logic       sid_link, sid_contender, short_reset_req, short_reset_drive, link_on_irq;
    logic [2:0] sid_pwr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    phy_csr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .strap_speed(strap_speed), .strap_contender(strap_contender),
        .strap_pwr(strap_pwr), .strap_susres(strap_susres), .lps(lps), .cps(cps),
        .loop_det(loop_det), .timeout_evt(timeout_evt), .port_resume(port_resume),
        .bus_reset_start(bus_reset_start), .sid_link(sid_link),
        .sid_contender(sid_contender), .sid_pwr(sid_pwr),
        .short_reset_req(short_reset_req), .short_reset_drive(short_reset_drive),
        .link_on_irq(link_on_irq)
    );

    // ---------------- behavioural reference model ----------------
    logic       m_la = 1'b1, m_con = 1'b0, m_wd = 1'b0, m_isbr = 1'b0;
    logic       m_loop = 1'b0, m_pf = 1'b1, m_to = 1'b0, m_pe = 1'b0;
    logic [2:0] m_pwr = '0;
    logic [7:0] m_rd = '0;
    int         m_cnt = 0;
    int         cps_seen[$] = '{0, 0, 0};   // newest sample first

    function automatic logic [7:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return 8'h20;
            2'd1: return {(strap_speed ? 3'b010 : 3'b001), 3'b010, m_la, m_con};
            2'd2: return {m_pwr, m_wd, m_isbr, m_loop, m_pf, 1'b0};
            default: return {6'b0, m_to, m_pe};
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_la = 1'b1; m_con = strap_contender; m_pwr = strap_pwr; m_wd = 1'b0;
            m_isbr = 1'b0; m_cnt = 0; m_loop = 1'b0; m_pf = 1'b1; m_to = 1'b0;
            m_pe = 1'b0; m_rd = '0; cps_seen = '{0, 0, 0};
        end else begin
            bit fell, pe_ev, w1, w2, w3;
            if (reg_rd) m_rd = model_read(reg_addr);
            fell  = (cps_seen[2] == 1) && (cps_seen[1] == 0);
            pe_ev = m_wd && strap_susres && (port_resume != 0);
            w1 = reg_wr && reg_addr == 2'd1;
            w2 = reg_wr && reg_addr == 2'd2;
            w3 = reg_wr && reg_addr == 2'd3;
            if (pe_ev) m_pe = 1'b1; else if (w3 && reg_wdata[0]) m_pe = 1'b0;
            if (timeout_evt) m_to = 1'b1; else if (w3 && reg_wdata[1]) m_to = 1'b0;
            if (loop_det) m_loop = 1'b1; else if (w2 && reg_wdata[2]) m_loop = 1'b0;
            if (fell) m_pf = 1'b1; else if (w2 && reg_wdata[1]) m_pf = 1'b0;
            if (bus_reset_start && m_isbr) begin
                m_isbr = 1'b0; m_cnt = SHORT_EXP;
            end else begin
                if (w2 && reg_wdata[3]) m_isbr = 1'b1;
                if (m_cnt > 0) m_cnt--;
            end
            if (w1) begin m_la = reg_wdata[1]; m_con = reg_wdata[0]; end
            if (w2) begin m_pwr = reg_wdata[7:5]; m_wd = reg_wdata[4]; end
            cps_seen.push_front(int'(cps));
            void'(cps_seen.pop_back());
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R12 rdata", reg_rdata, m_rd);
        chk("R3 sid_link", 8'(sid_link), 8'(m_la & lps));
        chk("R3 sid_contender", 8'(sid_contender), 8'(m_con));
        chk("R3 sid_pwr", 8'(sid_pwr), 8'(m_pwr));
        chk("R7 short_reset_req", 8'(short_reset_req), 8'(m_isbr));
        chk("R8 short_reset_drive", 8'(short_reset_drive), 8'(m_cnt != 0));
        chk("R11 link_on_irq", 8'(link_on_irq), 8'((lps | m_wd) & (m_loop | m_pf | m_to)));
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) compare_all();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a; reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int n;
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (4) tick();

        rd(2'd0, 8'h20, "R1 caps at reset");
        rd(2'd1, 8'h4B, "R2 link reg, strap high");
        rd(2'd2, 8'hA2, "R6 R4 ctrl reset values");
        rd(2'd3, 8'h00, "R9 event reg reset");
        chk("R3 sid_pwr from strap", 8'(sid_pwr), 8'h05);
        chk("R3 sid_contender from strap", 8'(sid_contender), 8'h01);
        chk("R11 irq on power-fail", 8'(link_on_irq), 8'h01);

        wr(2'd0, 8'hFF);
        rd(2'd0, 8'h20, "R1 read-only after write");
        wr(2'd1, 8'h00);
        chk("R3 link inactive", 8'(sid_link), 8'h00);
        rd(2'd1, 8'h48, "R2 only low bits written");
        wr(2'd1, 8'h02);
        lps = 1'b0; tick();
        chk("R3 lps low masks link", 8'(sid_link), 8'h00);
        lps = 1'b1; tick();
        chk("R3 link active", 8'(sid_link), 8'h01);

        wr(2'd2, 8'hA2);
        rd(2'd2, 8'hA0, "R6 power-fail cleared");
        chk("R11 no flags no irq", 8'(link_on_irq), 8'h00);
        cps = 1'b0; tick(); tick();
        chk("R6 not yet after two edges", 8'(link_on_irq), 8'h00);
        tick();
        chk("R6 set on third edge", 8'(link_on_irq), 8'h01);
        cps = 1'b1;
        wr(2'd2, 8'hA2);
        repeat (3) tick();

        loop_det = 1'b1; tick(); loop_det = 1'b0;
        rd(2'd2, 8'hA4, "R5 loop set");
        wr(2'd2, 8'hA0);
        rd(2'd2, 8'hA4, "R5 write 0 ignored");
        loop_det = 1'b1; wr(2'd2, 8'hA4); loop_det = 1'b0;
        rd(2'd2, 8'hA4, "R5 set beats clear");
        wr(2'd2, 8'hA4);
        rd(2'd2, 8'hA0, "R5 cleared");

        wr(2'd2, 8'h60);
        chk("R4 power class written", 8'(sid_pwr), 8'h03);
        wr(2'd2, 8'hA0);

        lps = 1'b0;
        timeout_evt = 1'b1; tick(); timeout_evt = 1'b0; tick();
        chk("R11 suppressed lps0 wd0", 8'(link_on_irq), 8'h00);
        rd(2'd3, 8'h02, "R9 timeout set");
        wr(2'd2, 8'hB0);
        chk("R11 watchdog enables irq", 8'(link_on_irq), 8'h01);
        wr(2'd3, 8'h02);
        rd(2'd3, 8'h00, "R9 timeout cleared");
        chk("R11 irq drops", 8'(link_on_irq), 8'h00);
        lps = 1'b1;

        port_resume = 2'b10; tick(); port_resume = '0;
        rd(2'd3, 8'h01, "R10 resume on port 1");
        wr(2'd3, 8'h01);
        wr(2'd2, 8'hA0);
        port_resume = 2'b01; tick(); port_resume = '0;
        rd(2'd3, 8'h00, "R10 watchdog off blocks");

        wr(2'd2, 8'hA8);
        chk("R7 request set", 8'(short_reset_req), 8'h01);
        repeat (3) tick();
        chk("R7 request held", 8'(short_reset_req), 8'h01);
        bus_reset_start = 1'b1; tick(); bus_reset_start = 1'b0;
        chk("R7 request self-cleared", 8'(short_reset_req), 8'h00);
        n = 0;
        while (short_reset_drive && n < 1000) begin
            n++;
            tick();
        end
        chk("R8 pulse length", 8'(n), 8'(SHORT_EXP));
        rd(2'd2, 8'hA0, "R7 bit reads 0");
        bus_reset_start = 1'b1; tick(); bus_reset_start = 1'b0;
        chk("R8 no request no drive", 8'(short_reset_drive), 8'h00);

        strap_speed = 1'b0; strap_contender = 1'b0; strap_pwr = 3'b010; strap_susres = 1'b0;
        rst_n = 1'b0; tick(); tick();
        rst_n = 1'b1; tick();
        rd(2'd1, 8'h2A, "R2 link reg, strap low");
        chk("R3 contender strap low", 8'(sid_contender), 8'h00);
        rd(2'd2, 8'h42, "R4 power class strap");
        wr(2'd2, 8'h52);
        port_resume = 2'b11; tick(); port_resume = '0;
        rd(2'd3, 8'h00, "R10 suspend strap low blocks");
        repeat (2) tick();

        summary();
        $finish;
    end
endmodule